// File: doc/BRIEF.md
# Scheduler Reschedule Interrupt Generator

This block helps an operating-system task scheduler decide when to preempt. Software keeps a running-priority register for each hardware thread, up to eight of them. It also keeps one "best waiting" register that holds the priority of the most urgent task still waiting in the ready queue. Priorities are 9 bits wide, and a larger number means a less urgent task.

While detection is enabled, the block compares every thread's running priority with the best-waiting value on every cycle. If any thread runs something less urgent than the waiting task, the block raises a one-cycle reschedule interrupt. It also sets a sticky pending flag. On that same edge it reloads the best-waiting register with the idle value 0x1FF. No 9-bit priority can be larger than 0x1FF, so the interrupt stays quiet until software programs the next waiting task.

Software reaches the block through a simple single-cycle register port. Writes land on the clock edge. Reads are combinational on the current address.

Top module: `sched_resched_top`

## Requirements
- R1: The enable flag is bit 0 at address 0 and is 0 after reset. While it is 0, no interrupt fires and the best-waiting register is not reloaded, whatever the priorities hold.
- R2: The best-waiting register is at address 1, 9 bits wide. It reads back what was last written and reads 0x1FF after reset.
- R3: The running priority of thread i is at address 8+i, 9 bits wide. It reads back what was last written and reads 0 after reset.
- R4: In a cycle where the enable flag is 1 and some thread's priority is strictly greater than the best-waiting value, `reschedIrq` is 1 in the following cycle. An equal priority does not fire.
- R5: The edge that raises `reschedIrq` also loads 0x1FF into the best-waiting register. `reschedIrq` is never high in two consecutive cycles.
- R6: While the best-waiting register holds 0x1FF, no interrupt fires.
- R7: The pending flag is bit 0 at address 2 and drives `irqPending`. It is set on the edge that raises `reschedIrq`. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. A set and a clear on the same edge leave it set.
- R8: A software write to the best-waiting register on the same edge as a trigger is lost: the register becomes 0x1FF.
- R9: Writes to unmapped addresses (3 to 7) change no register. Reads of those addresses return 0.
- R10: After reset, `reschedIrq` and `irqPending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Register address |
| regWrData | input | PRIO_W (9) | Write data |
| regRdData | output | PRIO_W (9) | Read data for regAddr, zero-extended |
| reschedIrq | output | 1 | One-cycle reschedule interrupt |
| irqPending | output | 1 | Sticky pending flag |

## Verification
Embedded properties check on every cycle that:
- the interrupt never fires while disabled,
- a fire is never followed by a second fire on the next cycle,
- every fire leaves the best-waiting register at 0x1FF and the pending flag set,
- the idle value never reports a worse thread,
- at most one thread register is written per cycle.

Some behaviours appear only through the bench's scenarios, which compare the block against a reference model:
- strict versus equal comparison,
- idle reload winning over a same-cycle software write,
- the set-over-clear race on the pending flag,
- unmapped writes being ignored,
- register read-back.

// File: rtl/sched_resched_pkg.sv
package sched_resched_pkg;

  // Register addresses. Thread priorities start at THREAD_BASE.
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_BEST   = 1;
  localparam int ADDR_PEND   = 2;
  localparam int THREAD_BASE = 8;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic wrBest;    // software write to the best-waiting register
    logic wrThread;  // software write to some thread priority register
    logic loadIdle;  // trigger: reload best-waiting with the idle value
  } dpStrobe_t;

endpackage

// File: rtl/sched_resched_ctrl.sv
module sched_resched_ctrl
  import sched_resched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  input  logic              anyWorse,
  output dpStrobe_t         strobe,
  output logic              enableQ,
  output logic              pendingQ,
  output logic              irqQ
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_BEST   = ADDR_W'(ADDR_BEST);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(ADDR_PEND);
  localparam logic [ADDR_W-1:0] A_THR_LO = ADDR_W'(THREAD_BASE);
  localparam int               THR_HI   = THREAD_BASE + NUM_THREADS;

  logic fire;
  logic hitThread;

  assign hitThread = (regAddr >= A_THR_LO) && (int'(regAddr) < THR_HI);
  assign fire      = enableQ && anyWorse;

  always_comb begin
    strobe          = '0;
    strobe.wrBest   = regWrEn && (regAddr == A_BEST);
    strobe.wrThread = regWrEn && hitThread;
    strobe.loadIdle = fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      pendingQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      irqQ <= fire;
      if (regWrEn && (regAddr == A_CTRL)) enableQ <= wrBit0;
      if (fire) pendingQ <= 1'b1;
      else if (regWrEn && (regAddr == A_PEND) && wrBit0) pendingQ <= 1'b0;
    end
  end

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !irqQ);  // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> !irqQ);  // R5
  AST_PEND_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> pendingQ);  // R7

endmodule

// File: rtl/sched_resched_dp.sv
module sched_resched_dp
  import sched_resched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int PRIO_W      = 9,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PRIO_W-1:0] wrPrio,
  input  logic              enableQ,
  input  logic              pendingQ,
  output logic              anyWorse,
  output logic [PRIO_W-1:0] rdData
);

  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  logic [PRIO_W-1:0]      bestQ;
  logic [PRIO_W-1:0]      prioQ [NUM_THREADS];
  logic [NUM_THREADS-1:0] wrVec;
  logic [NUM_THREADS-1:0] worseVec;

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(THREAD_BASE + i);
    assign wrVec[i]    = strobe.wrThread && (regAddr == MY_ADDR);
    assign worseVec[i] = prioQ[i] > bestQ;   // larger value = worse
  end

  assign anyWorse = |worseVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestQ <= IDLE_PRIO;
      for (int i = 0; i < NUM_THREADS; i++) prioQ[i] <= '0;
    end else begin
      if (strobe.loadIdle)    bestQ <= IDLE_PRIO;  // trigger wins over software
      else if (strobe.wrBest) bestQ <= wrPrio;
      for (int i = 0; i < NUM_THREADS; i++)
        if (wrVec[i]) prioQ[i] <= wrPrio;
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) rdData = PRIO_W'(enableQ);
    if (regAddr == ADDR_W'(ADDR_BEST)) rdData = bestQ;
    if (regAddr == ADDR_W'(ADDR_PEND)) rdData = PRIO_W'(pendingQ);
    for (int i = 0; i < NUM_THREADS; i++)
      if (regAddr == ADDR_W'(THREAD_BASE + i)) rdData = prioQ[i];
  end

  AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadIdle |=> bestQ == IDLE_PRIO);  // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    bestQ == IDLE_PRIO |-> !anyWorse);  // R6
  AST_ONE_THREAD_WR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));  // R3

endmodule

// File: rtl/sched_resched_top.sv
module sched_resched_top
  import sched_resched_pkg::*;
#(
  parameter  int NUM_THREADS = 8,
  parameter  int PRIO_W      = 9,
  localparam int ADDR_W      = $clog2(THREAD_BASE + NUM_THREADS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PRIO_W-1:0] regWrData,
  output logic [PRIO_W-1:0] regRdData,
  output logic              reschedIrq,
  output logic              irqPending
);

  dpStrobe_t strobe;
  logic      enableQ;
  logic      anyWorse;

  sched_resched_ctrl #(
    .NUM_THREADS(NUM_THREADS),
    .ADDR_W     (ADDR_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrBit0  (regWrData[0]),
    .anyWorse(anyWorse),
    .strobe  (strobe),
    .enableQ (enableQ),
    .pendingQ(irqPending),
    .irqQ    (reschedIrq)
  );

  sched_resched_dp #(
    .NUM_THREADS(NUM_THREADS),
    .PRIO_W     (PRIO_W),
    .ADDR_W     (ADDR_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regAddr (regAddr),
    .wrPrio  (regWrData),
    .enableQ (enableQ),
    .pendingQ(irqPending),
    .anyWorse(anyWorse),
    .rdData  (regRdData)
  );

endmodule

// File: tb/sched_resched_top_tb_top.sv
module sched_resched_top_tb_top;

  localparam int NT = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [8:0] regWrData = '0;
  logic [8:0] regRdData;
  logic       reschedIrq;
  logic       irqPending;

  int testCount = 0;
  int failCount = 0;

  // reference model state
  logic [8:0] mPrio [NT];
  logic [8:0] mBest;
  logic       mEn;
  logic       mPend;

  always #10 clk = ~clk;  // 50 MHz

  sched_resched_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .reschedIrq(reschedIrq), .irqPending(irqPending)
  );

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] modelRead(input logic [3:0] a);
    if (a == 4'd0) return {8'd0, mEn};
    if (a == 4'd1) return mBest;
    if (a == 4'd2) return {8'd0, mPend};
    if (a >= 4'd8) return mPrio[a - 4'd8];
    return 9'd0;
  endfunction

  function automatic string reqFor(input logic [3:0] a);
    if (a == 4'd0) return "R1";
    if (a == 4'd1) return "R2";
    if (a == 4'd2) return "R7";
    if (a >= 4'd8) return "R3";
    return "R9";
  endfunction

  function automatic bit modelTrig();
    bit w = 0;
    for (int i = 0; i < NT; i++) if (mPrio[i] > mBest) w = 1;
    return mEn && w;
  endfunction

  // One bus cycle: drive, check read (pre-edge state), clock, check irq/pending.
  task automatic doCycle(input bit we, input logic [3:0] a, input logic [8:0] d);
    bit trig;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d;
    #1;
    if (!we) check(regRdData == modelRead(a), reqFor(a), regRdData, modelRead(a));
    trig = modelTrig();
    @(posedge clk);
    if (trig) mBest = 9'h1FF;
    else if (we && a == 4'd1) mBest = d;
    if (trig) mPend = 1'b1;
    else if (we && a == 4'd2 && d[0]) mPend = 1'b0;
    if (we && a == 4'd0) mEn = d[0];
    if (we && a >= 4'd8) mPrio[a - 4'd8] = d;
    #1;
    check(reschedIrq == trig, "R4", {8'd0, reschedIrq}, {8'd0, trig});
    check(irqPending == mPend, "R7", {8'd0, irqPending}, {8'd0, mPend});
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic [8:0] exp);
    doCycle(1'b0, a, 9'd0);
    @(negedge clk); regWrEn = 1'b0; regAddr = a; #1;
    check(regRdData == exp, req, regRdData, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : main
    logic [3:0] a;
    logic [8:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NT; i++) mPrio[i] = 9'd0;
    mBest = 9'h1FF; mEn = 1'b0; mPend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R10 reset state
    check(reschedIrq == 1'b0, "R10", {8'd0, reschedIrq}, 9'd0);
    check(irqPending == 1'b0, "R10", {8'd0, irqPending}, 9'd0);
    rd(4'd1, "R2", 9'h1FF);
    rd(4'd0, "R1", 9'd0);
    rd(4'd9, "R3", 9'd0);

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom % 10;
      if (sel < 1)      a = 4'd0;
      else if (sel < 3) a = 4'd1;
      else if (sel < 4) a = 4'd2;
      else if (sel < 5) a = 4'($urandom % 8);
      else              a = 4'd8 + 4'($urandom % NT);
      d = 9'h1E0 + 9'($urandom % 32);
      if ($urandom % 4 == 0) d = 9'($urandom % 512);
      if (a == 4'd0) d = ($urandom % 6 == 0) ? 9'd0 : 9'd1;
      doCycle(($urandom % 10) < 7, a, d);
    end

    // directed corner cases
    for (int i = 0; i < NT; i++) doCycle(1'b1, 4'd8 + 4'(i), 9'd0);
    doCycle(1'b1, 4'd2, 9'd1);
    doCycle(1'b1, 4'd0, 9'd1);
    doCycle(1'b1, 4'd1, 9'h1FF);
    doCycle(1'b1, 4'd11, 9'h1FF);
    doCycle(1'b0, 4'd0, 9'd0);
    check(reschedIrq == 1'b0, "R6", {8'd0, reschedIrq}, 9'd0);
    doCycle(1'b1, 4'd11, 9'h040);
    doCycle(1'b1, 4'd1, 9'h040);     // equal priority
    doCycle(1'b0, 4'd0, 9'd0);
    check(reschedIrq == 1'b0, "R4 equal", {8'd0, reschedIrq}, 9'd0);
    doCycle(1'b1, 4'd11, 9'h041);    // now worse
    doCycle(1'b0, 4'd0, 9'd0);
    check(reschedIrq == 1'b1, "R4 worse", {8'd0, reschedIrq}, 9'd1);
    rd(4'd1, "R5", 9'h1FF);
    check(reschedIrq == 1'b0, "R5", {8'd0, reschedIrq}, 9'd0);
    // R8: software write to best-waiting on the trigger edge
    doCycle(1'b1, 4'd1, 9'h010);
    doCycle(1'b1, 4'd1, 9'h005);
    check(reschedIrq == 1'b1, "R8", {8'd0, reschedIrq}, 9'd1);
    rd(4'd1, "R8", 9'h1FF);
    // R7: W1C, write 0 no effect, set beats clear
    doCycle(1'b1, 4'd2, 9'd0);
    check(irqPending == 1'b1, "R7 w0", {8'd0, irqPending}, 9'd1);
    doCycle(1'b1, 4'd2, 9'd1);
    check(irqPending == 1'b0, "R7 w1c", {8'd0, irqPending}, 9'd0);
    doCycle(1'b1, 4'd1, 9'h010);
    doCycle(1'b1, 4'd2, 9'd1);
    check(irqPending == 1'b1, "R7 race", {8'd0, irqPending}, 9'd1);
    // R9: unmapped writes
    doCycle(1'b1, 4'd5, 9'h1AB);
    rd(4'd5, "R9", 9'd0);
    rd(4'd1, "R9 best", 9'h1FF);
    rd(4'd0, "R9 ctrl", 9'd1);
    // R1: disabled
    doCycle(1'b1, 4'd0, 9'd0);
    doCycle(1'b1, 4'd1, 9'h010);
    doCycle(1'b0, 4'd0, 9'd0);
    doCycle(1'b0, 4'd0, 9'd0);
    check(reschedIrq == 1'b0, "R1", {8'd0, reschedIrq}, 9'd0);
    rd(4'd1, "R1 best kept", 9'h010);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule